// File: doc/BRIEF.md
# Scan-Mode ADC Channel Sequencer

This block sequences an external successive-approximation converter core through a programmable group of analog channels. The group is given as a starting channel and a length of one to four, and is visited in ascending channel order. Once software sets the run bit, the block waits for a short start delay that is aligned to an internal prescaler phase. It then opens a conversion window for each channel in turn. At the end of each window it asks the core for the result, and it stores the returned 10-bit value in that channel's data register.

After the last channel of the group, the block raises a sticky end-of-scan flag and drives its interrupt line if interrupts are enabled. It then wraps back to the first channel of the group. Scanning continues until software clears the run bit. The first window after every start is longer than the windows that follow it, and a speed-select bit doubles both window lengths. Clearing the run bit abandons the conversion in progress. A later start begins again at the first channel of the group, using the long timing.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the control word reads 0, every data register reads 0, and `irq`, `conv_start` and `conv_sample` are all 0.
- R2: The first `conv_start` after the run bit (control bit 0) is written to 1 appears 2 to PRE_DIV+1 cycles after the write edge. The exact count depends on the prescaler phase at the time of the write.
- R3: The first conversion window of a run, counted from the `conv_start` cycle through the `conv_sample` cycle inclusive, lasts FIRST_CYC cycles when control bit 3 (slow) is 0. `conv_sample` is always followed by a wait for `conv_done`.
- R4: Each later window in the same run lasts LATER_CYC cycles. With slow set to 1, both window lengths are doubled.
- R5: Channels are visited in ascending order, modulo NUM_CH, from the first channel (control bits 10:8) for count+1 channels (count in control bits 5:4). Each `conv_result` that arrives with `conv_done` is written to the data register of the channel being converted, which is read at address 8+channel. Channels outside the group are not written.
- R6: When the last channel of the group is stored, the end flag (control bit 2) becomes 1 and scanning resumes at the first channel. The run bit is never cleared by hardware.
- R7: `irq` is 1 exactly while the end flag is 1 and interrupt enable (control bit 1) is 1.
- R8: Writing 0 to the flag bit clears the flag, and writing 1 to it has no effect. An end-of-scan event in the same cycle as a clearing write leaves the flag at 1.
- R9: Clearing the run bit during a conversion abandons that conversion. No data register is written and no further `conv_start` appears. A later start begins at the first channel of the group, with the FIRST_CYC window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 = control word) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address (0 = control, 8+n = data of channel n) |
| rd_data | output | 16 | Read data, combinational |
| conv_start | output | 1 | One-cycle pulse that opens a conversion window |
| conv_sample | output | 1 | One-cycle pulse that closes the window and requests the result |
| conv_ch | output | 3 | Channel under conversion |
| conv_done | input | 1 | Result-valid strobe from the core |
| conv_result | input | 10 | Conversion result |
| irq | output | 1 | End-of-scan interrupt request |

## Verification
The end-of-scan event and a software write that clears the flag can land on the same clock edge. To provoke this, the bench watches for `conv_sample` on the last channel of the group. It then issues the clearing control write in the exact cycle in which its core model returns `conv_done`. The flag is already set before this write, so a design that lets the clear win reads back 0, while the required behaviour reads back 1.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_CONV  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    localparam int CTRL_W    = 16;
    localparam int BIT_RUN   = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_FLAG  = 2;
    localparam int BIT_SLOW  = 3;
    localparam int CNT_LSB   = 4;
    localparam int FIRST_LSB = 8;

endpackage

// File: rtl/adc_seq_phase.sv
module adc_seq_phase #(
    parameter int PRE_DIV = 4,
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_zero
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        if (pre_q == PRE_W'(PRE_DIV - 1)) pre_d = '0;
        else                              pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign phase_zero = (pre_q == '0);
endmodule

// File: rtl/adc_seq_datareg.sv
module adc_seq_datareg #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wch,
    input  logic [RES_W-1:0] wdata,
    input  logic [CH_W-1:0]  rch,
    output logic [RES_W-1:0] rdata
);
    logic [RES_W-1:0] reg_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [RES_W-1:0] reg_d;
        always_comb begin
            reg_d = reg_q[g];
            if (we && (wch == CH_W'(g))) reg_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q[g] <= '0;
            else        reg_q[g] <= reg_d;
        end
    end

    assign rdata = reg_q[rch];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int RES_W     = 10,
    parameter int FIRST_CYC = 266,
    parameter int LATER_CYC = 256,
    parameter int PRE_DIV   = 4,
    parameter int GRP_W     = 2,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int ADDR_W   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              conv_start,
    output logic              conv_sample,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    localparam int CNT_W = $clog2(2 * FIRST_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             run;
        logic             ie;
        logic             flag;
        logic             slow;
        logic [GRP_W-1:0] cnt_m1;
        logic [CH_W-1:0]  first;
        logic [CH_W-1:0]  ch;
        logic [GRP_W-1:0] idx;
        logic             first_pass;
        logic             kick;
        logic [CNT_W-1:0] tmr;
    } seq_t;

    seq_t s_d, s_q;

    logic             phase_zero;
    logic [CNT_W-1:0] limit;
    logic             ctrl_wr;
    logic             store;
    logic             last;
    logic             end_evt;
    logic             win_end;
    logic [RES_W-1:0] data_rd;
    logic [15:0]      ctrl_rd;

    adc_seq_phase #(.PRE_DIV(PRE_DIV)) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_zero (phase_zero)
    );

    adc_seq_datareg #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store),
        .wch   (s_q.ch),
        .wdata (conv_result),
        .rch   (rd_addr[CH_W-1:0]),
        .rdata (data_rd)
    );

    always_comb begin
        limit   = s_q.first_pass ? CNT_W'(FIRST_CYC) : CNT_W'(LATER_CYC);
        if (s_q.slow) limit = limit << 1;
        win_end = (s_q.tmr >= limit - CNT_W'(1));
        ctrl_wr = wr_en && (wr_addr == '0);
        store   = (s_q.st == ST_WAIT) && conv_done && s_q.run;
        last    = (s_q.idx == s_q.cnt_m1);
        end_evt = store && last;

        s_d      = s_q;
        s_d.kick = 1'b0;

        if (ctrl_wr) begin
            s_d.run    = wr_data[BIT_RUN];
            s_d.ie     = wr_data[BIT_IE];
            s_d.slow   = wr_data[BIT_SLOW];
            s_d.cnt_m1 = wr_data[CNT_LSB +: GRP_W];
            s_d.first  = wr_data[FIRST_LSB +: CH_W];
            if (!wr_data[BIT_FLAG]) s_d.flag = 1'b0;
        end
        if (end_evt) s_d.flag = 1'b1;

        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.run) begin
                    s_d.st         = ST_DELAY;
                    s_d.ch         = s_q.first;
                    s_d.idx        = '0;
                    s_d.first_pass = 1'b1;
                end
            end
            ST_DELAY: begin
                if (phase_zero) begin
                    s_d.st   = ST_CONV;
                    s_d.tmr  = '0;
                    s_d.kick = 1'b1;
                end
            end
            ST_CONV: begin
                if (win_end) s_d.st = ST_WAIT;
                else         s_d.tmr = s_q.tmr + CNT_W'(1);
            end
            ST_WAIT: begin
                if (store) begin
                    s_d.st         = ST_CONV;
                    s_d.tmr        = '0;
                    s_d.kick       = 1'b1;
                    s_d.first_pass = 1'b0;
                    if (last) begin
                        s_d.ch  = s_q.first;
                        s_d.idx = '0;
                    end else begin
                        s_d.ch  = s_q.ch + CH_W'(1);
                        s_d.idx = s_q.idx + GRP_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (!s_q.run) begin
            s_d.st   = ST_IDLE;
            s_d.kick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_rd                      = '0;
        ctrl_rd[BIT_RUN]             = s_q.run;
        ctrl_rd[BIT_IE]              = s_q.ie;
        ctrl_rd[BIT_FLAG]            = s_q.flag;
        ctrl_rd[BIT_SLOW]            = s_q.slow;
        ctrl_rd[CNT_LSB +: GRP_W]    = s_q.cnt_m1;
        ctrl_rd[FIRST_LSB +: CH_W]   = s_q.first;
        if (rd_addr == '0)              rd_data = ctrl_rd;
        else if (rd_addr[ADDR_W-1])     rd_data = {{(16 - RES_W){1'b0}}, data_rd};
        else                            rd_data = '0;
    end

    assign conv_start  = s_q.kick && s_q.run;
    assign conv_sample = (s_q.st == ST_CONV) && win_end && s_q.run;
    assign conv_ch     = s_q.ch;
    assign irq         = s_q.flag && s_q.ie;

    // R3
    sample_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_sample |=> (s_q.st == ST_WAIT) || !s_q.run);

    // R5
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CONV && s_q.run) |=> $stable(conv_ch));

    // R6
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> s_q.flag);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.flag) && s_q.ie) |-> irq);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && !s_q.run) |=> (s_q.st == ST_IDLE) && !conv_start);
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
    localparam int FC = 266;
    localparam int LC = 256;
    localparam int PD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    wire  [15:0] rd_data;
    wire         conv_start, conv_sample, irq;
    wire  [2:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;

    int checks = 0, errors = 0, cyc = 0;
    int n_st = 0, n_sm = 0, last_start = 0, base = 100;
    int st_ch [64];
    int st_cyc[64];
    int win   [64];
    logic [2:0] cur_ch = '0;
    logic       pend = 1'b0;
    logic [9:0] exp_d [8];

    always #5 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .conv_start(conv_start),
        .conv_sample(conv_sample), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always begin
        @(negedge clk); #1;
        if (conv_start) begin
            if (n_st < 64) begin st_ch[n_st] = conv_ch; st_cyc[n_st] = cyc; end
            n_st++; last_start = cyc; cur_ch = conv_ch;
        end
        if (conv_sample) begin
            if (n_sm < 64) win[n_sm] = cyc - last_start + 1;
            n_sm++;
        end
    end

    // core model: done two negedges after the sample pulse
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (pend) begin
            conv_done = 1'b1;
            conv_result = 10'(base + int'(cur_ch) * 37);
            exp_d[cur_ch] = conv_result;
            pend = 1'b0;
        end
        if (conv_sample) pend = 1'b1;
    end

    function automatic logic [15:0] cw(input bit run, input bit ie, input bit flag,
                                       input bit slow, input int cnt_m1, input int first);
        logic [15:0] w;
        w = '0;
        w[0] = run; w[1] = ie; w[2] = flag; w[3] = slow;
        w[5:4] = 2'(cnt_m1); w[10:8] = 3'(first);
        return w;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = '0; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output int v);
        @(negedge clk); rd_addr = 4'(addr); #1 v = int'(rd_data);
    endtask

    task automatic wait_samples(input int n);
        while (n_sm < n) @(negedge clk);
    endtask

    task automatic stop_mid(input int cnt_m1, input int first);
        int n0;
        n0 = n_st;
        while (n_st <= n0) begin @(negedge clk); #2; end
        repeat (20) @(negedge clk);
        wr_ctrl(cw(0, 0, 0, 0, cnt_m1, first));
    endtask

    task automatic t_reset();
        int v;
        rd(0, v);  chk("R1 ctrl after reset", v, 0);
        rd(11, v); chk("R1 data3 after reset", v, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 conv_start after reset", conv_start, 0);
    endtask

    task automatic t_scan();
        int v, wcyc, d;
        n_st = 0; n_sm = 0; base = 100;
        wr_ctrl(cw(1, 1, 0, 0, 2, 2));
        wcyc = cyc;
        wait_samples(5);
        d = st_cyc[0] - wcyc;
        chk("R2 start delay in range", int'(d >= 2 && d <= PD + 1), 1);
        chk("R3 first window", win[0], FC);
        for (int i = 1; i < 5; i++) chk("R4 later window", win[i], LC);
        chk("R5 order ch0", st_ch[0], 2);
        chk("R5 order ch1", st_ch[1], 3);
        chk("R5 order ch2", st_ch[2], 4);
        chk("R6 wrap to first", st_ch[3], 2);
        for (int c = 2; c < 5; c++) begin rd(8 + c, v); chk("R5 data stored", v, int'(exp_d[c])); end
        rd(8 + 5, v); chk("R5 outside group untouched", v, 0);
        rd(0, v);
        chk("R6 flag set", (v >> 2) & 1, 1);
        chk("R6 run kept", v & 1, 1);
        chk("R7 irq with ie", irq, 1);
    endtask

    task automatic t_clear();
        int v;
        wr_ctrl(cw(1, 1, 0, 0, 2, 2));
        rd(0, v);
        chk("R8 flag cleared", (v >> 2) & 1, 0);
        chk("R7 irq low after clear", irq, 0);
        while (!irq) @(negedge clk);
        rd(0, v); chk("R6 flag on next scan", (v >> 2) & 1, 1);
    endtask

    task automatic t_same();
        int v;
        forever begin @(negedge clk); if (conv_sample && conv_ch == 3'd4) break; end
        @(negedge clk); wr_en = 1'b1; wr_addr = '0; wr_data = cw(1, 1, 0, 0, 2, 2);
        @(negedge clk); wr_en = 1'b0;
        rd(0, v); chk("R8 end event beats clear", (v >> 2) & 1, 1);
    endtask

    task automatic t_stop();
        int v, x, n0;
        n0 = n_st;
        while (n_st <= n0) begin @(negedge clk); #2; end
        x = cur_ch;
        repeat (20) @(negedge clk);
        base = 500;
        wr_ctrl(cw(0, 1, 1, 0, 2, 2));
        n0 = n_st;
        repeat (700) @(negedge clk);
        chk("R9 no start after stop", n_st, n0);
        rd(8 + x, v); chk("R9 abandoned data kept", v, int'(exp_d[x]));
        rd(0, v);     chk("R8 write 1 keeps flag", (v >> 2) & 1, 1);
        wr_ctrl(cw(0, 1, 0, 0, 2, 2));
        wr_ctrl(cw(0, 1, 1, 0, 2, 2));
        rd(0, v);     chk("R8 write 1 does not set flag", (v >> 2) & 1, 0);
        chk("R7 irq low with flag clear", irq, 0);
        n_st = 0; n_sm = 0;
        wr_ctrl(cw(1, 1, 0, 0, 2, 2));
        wait_samples(2);
        chk("R9 restart at first channel", st_ch[0], 2);
        chk("R9 restart long window", win[0], FC);
        chk("R4 window after restart", win[1], LC);
        rd(8 + 2, v); chk("R5 data after restart", v, int'(exp_d[2]));
        stop_mid(2, 2);
    endtask

    task automatic t_slow();
        int v;
        n_st = 0; n_sm = 0; base = 300;
        wr_ctrl(cw(1, 0, 0, 1, 3, 6));
        wait_samples(5);
        chk("R4 slow first window", win[0], 2 * FC);
        for (int i = 1; i < 5; i++) chk("R4 slow later window", win[i], 2 * LC);
        chk("R5 wrap order a", st_ch[1], 7);
        chk("R5 wrap order b", st_ch[2], 0);
        chk("R5 wrap order c", st_ch[3], 1);
        chk("R6 back to first", st_ch[4], 6);
        rd(8 + 0, v); chk("R5 data ch0", v, int'(exp_d[0]));
        rd(8 + 7, v); chk("R5 data ch7", v, int'(exp_d[7]));
        rd(0, v);     chk("R6 flag slow scan", (v >> 2) & 1, 1);
        chk("R7 irq masked", irq, 0);
        stop_mid(3, 6);
    endtask

    task automatic t_single();
        int v;
        n_st = 0; n_sm = 0; base = 40;
        wr_ctrl(cw(1, 1, 0, 0, 0, 5));
        wait_samples(3);
        chk("R5 single ch a", st_ch[1], 5);
        chk("R6 single ch b", st_ch[2], 5);
        chk("R3 single first window", win[0], FC);
        rd(8 + 5, v); chk("R5 single data", v, int'(exp_d[5]));
        chk("R7 single irq", irq, 1);
        stop_mid(0, 5);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) exp_d[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scan();
        t_clear();
        t_same();
        t_stop();
        t_slow();
        t_single();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule